// File: doc/BRIEF.md
# Victim Line Buffer

This block keeps a few recently discarded lines from a direct-mapped data cache. When the main cache replaces a line, it hands the line to this buffer on the eviction port. The line is then held here and is not sent straight to lower memory. Every entry has its own address register and comparator, so a lookup checks all entries in the same cycle. The buffer stores the full line address because it has no set indexing.

When the main cache misses, it presents the missing line address on the lookup port, together with the line it would displace. On a buffer hit the two lines trade places. The found line is returned with its dirty bit, and the displaced line takes over the freed entry. A conflict miss in the main cache is then served without going to the next level. A lookup that finds nothing changes no state.

When the buffer is full, a new eviction replaces the entry that was placed in the buffer longest ago. If that entry is dirty, it leaves on the writeback port toward lower memory. All responses are registered and appear one cycle after the request.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid: `resp_valid` and `wb_valid` are low, and a lookup of any address reports a miss.
- R2: A lookup presented with `lk_valid` high in one cycle produces `resp_valid` high in the next cycle. On a hit, `resp_hit` is 1 and `resp_data` is the stored line. On a miss, `resp_hit` is 0.
- R3: A lookup that matches no valid entry leaves all entries, their dirty bits and the replacement order unchanged.
- R4: An eviction accepted while any entry is free is written into a free entry, with no writeback. Up to 4 lines are held together and each can be found again.
- R5: An eviction accepted while all 4 entries are valid replaces the entry inserted least recently. If that entry is dirty, `wb_valid` rises in the next cycle, with that entry's address on `wb_addr` and its data on `wb_data`.
- R6: When the replaced entry is clean, `wb_valid` stays low.
- R7: On a hit with `dp_valid` high, the displaced line (`dp_addr`, `dp_data`, `dp_dirty`) takes the hit entry. Afterwards the found line misses and the displaced line hits.
- R8: On a hit with `dp_valid` low, the hit entry becomes free. A later eviction fills that entry and does not replace any other valid line.
- R9: A line written into an entry by a swap counts as the newest insertion for the replacement order.
- R10: An eviction presented in the same cycle as a lookup is ignored. It causes no writeback and stores no line.
- R11: On a hit, `resp_dirty` equals the dirty bit stored with the line, whether that line came in by eviction or by swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Line address searched |
| dp_valid | input | 1 | A displaced line accompanies the lookup |
| dp_addr | input | ADDR_W | Displaced line address |
| dp_data | input | LINE_W | Displaced line data |
| dp_dirty | input | 1 | Displaced line is modified |
| ev_valid | input | 1 | Eviction request |
| ev_addr | input | ADDR_W | Evicted line address |
| ev_data | input | LINE_W | Evicted line data |
| ev_dirty | input | 1 | Evicted line is modified |
| resp_valid | output | 1 | Lookup response present |
| resp_hit | output | 1 | Lookup found the line |
| resp_data | output | LINE_W | Found line data (meaningful on hit) |
| resp_dirty | output | 1 | Found line dirty bit |
| wb_valid | output | 1 | Dirty line leaving toward lower memory |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | LINE_W | Writeback line data |

## Verification
The hardest case to reach is the replacement order after swaps have mixed into it. A line that comes in by a swap must outlast older evictions, and if it is dirty it must later leave on the writeback port. The stimulus fills the buffer and then swaps two dirty and clean lines back in. After a miss probe, it pushes four more evictions, so that each replacement in turn shows which line was judged oldest. A freed entry and a lookup that collides with an eviction are then tested on the same populated buffer.

// File: rtl/vb_pkg.sv
package vb_pkg;
  typedef struct packed {
    logic valid;
    logic dirty;
  } vb_meta_t;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  localparam int IW    = $clog2(N)
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N-1:0][ADDR_W-1:0] tags,
  input  logic [N-1:0]             valids,
  output logic                     hit,
  output logic [IW-1:0]            hit_idx,
  output logic                     has_free,
  output logic [IW-1:0]            free_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valids[g] && (tags[g] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) hit_idx = IW'(i);
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valids[i]) free_idx = IW'(i);
  end

  assign hit      = |match;
  assign has_free = ~&valids;
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int N   = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  logic [N-1:0][IW-1:0] rank;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rank[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          rank[i] <= '0;
        else if (rank[i] < rank[touch_idx]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++)
      if (rank[i] == IW'(N - 1)) oldest_idx = IW'(i);
  end
endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int N      = 4,
  parameter int LINE_W = 64,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic              re,
  input  logic [IW-1:0]     raddr,
  output logic [LINE_W-1:0] q
);
  logic [LINE_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int N      = 4,
  parameter int ADDR_W = 26,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              dp_valid,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic [LINE_W-1:0] dp_data,
  input  logic              dp_dirty,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [LINE_W-1:0] resp_data,
  output logic              resp_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  import vb_pkg::*;
  localparam int IW = $clog2(N);

  logic [N-1:0][ADDR_W-1:0] tags;
  vb_meta_t [N-1:0]         meta;
  logic [N-1:0]             valids;
  logic                     m_hit, has_free;
  logic [IW-1:0]            hit_idx, free_idx, oldest_idx, victim_idx, touch_idx;
  logic                     lk_hit, ev_take, touch;
  logic [LINE_W-1:0]        q;

  for (genvar g = 0; g < N; g++) begin : g_valid
    assign valids[g] = meta[g].valid;
  end

  vb_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .addr(lk_addr), .tags(tags), .valids(valids), .hit(m_hit),
    .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  // Lookup owns the cycle; an eviction in the same cycle is dropped.
  assign lk_hit     = lk_valid && m_hit;
  assign ev_take    = ev_valid && !lk_valid;
  assign victim_idx = has_free ? free_idx : oldest_idx;
  assign touch      = (lk_hit && dp_valid) || ev_take;
  assign touch_idx  = lk_hit ? hit_idx : victim_idx;

  vb_age #(.N(N)) u_age (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .oldest_idx(oldest_idx)
  );

  vb_store #(.N(N), .LINE_W(LINE_W)) u_store (
    .clk(clk), .we(touch), .waddr(touch_idx),
    .wdata(lk_hit ? dp_data : ev_data),
    .re(lk_valid || ev_take), .raddr(lk_valid ? hit_idx : victim_idx), .q(q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) meta[i] <= '0;
    end else if (lk_hit) begin
      if (dp_valid) begin
        tags[hit_idx] <= dp_addr;
        meta[hit_idx] <= '{valid: 1'b1, dirty: dp_dirty};
      end else begin
        meta[hit_idx] <= '0;
      end
    end else if (ev_take) begin
      tags[victim_idx] <= ev_addr;
      meta[victim_idx] <= '{valid: 1'b1, dirty: ev_dirty};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_dirty <= 1'b0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
    end else begin
      resp_valid <= lk_valid;
      resp_hit   <= lk_hit;
      resp_dirty <= lk_hit && meta[hit_idx].dirty;
      wb_valid   <= ev_take && !has_free && meta[oldest_idx].dirty;
      wb_addr    <= tags[victim_idx];
    end
  end

  assign resp_data = q;
  assign wb_data   = q;
endmodule

// File: rtl/victim_buffer_checker.sv
module victim_buffer_checker #(
  parameter int ADDR_W = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              ev_valid,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_dirty,
  input logic              wb_valid
);
  p_resp_follows_lookup_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid);
  p_resp_needs_lookup_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !resp_valid);
  p_hit_within_resp_r2: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);
  p_dirty_only_on_hit_r11: assert property (@(posedge clk) disable iff (rst)
    resp_dirty |-> resp_hit);
  p_wb_from_eviction_r5: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !wb_valid);
  p_no_wb_beside_lookup_r10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> !wb_valid);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !resp_valid && !wb_valid);
endmodule

bind victim_buffer victim_buffer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .ev_valid(ev_valid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_dirty(resp_dirty),
  .wb_valid(wb_valid)
);

// File: tb/victim_buffer_bench.sv
module victim_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int LW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, dp_valid = 0, dp_dirty = 0, ev_valid = 0, ev_dirty = 0;
  logic [AW-1:0] lk_addr = '0, dp_addr = '0, ev_addr = '0;
  logic [LW-1:0] dp_data = '0, ev_data = '0;
  logic resp_valid, resp_hit, resp_dirty, wb_valid;
  logic [LW-1:0] resp_data, wb_data;
  logic [AW-1:0] wb_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_buffer #(.N(4), .ADDR_W(AW), .LINE_W(LW)) u_victim_buffer (.*);

  function automatic logic [LW-1:0] ld(input logic [AW-1:0] a);
    return {a[11:0], 8'h5A, a[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic evict(input logic [AW-1:0] a, input logic d, input bit exp_wb,
                       input logic [AW-1:0] exp_a, input string req);
    @(negedge clk);
    ev_valid = 1; ev_addr = a; ev_data = ld(a); ev_dirty = d;
    @(negedge clk);
    ev_valid = 0;
    chk(wb_valid == exp_wb, req, 64'(wb_valid), 64'(exp_wb));
    if (exp_wb) begin
      chk(wb_addr == exp_a, req, 64'(wb_addr), 64'(exp_a));
      chk(wb_data == ld(exp_a), req, 64'(wb_data), 64'(ld(exp_a)));
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input bit dv, input logic [AW-1:0] da,
                        input logic dd, input bit exp_hit, input logic exp_d, input string req);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; dp_valid = dv; dp_addr = da; dp_data = ld(da); dp_dirty = dd;
    @(negedge clk);
    lk_valid = 0; dp_valid = 0;
    chk(resp_valid == 1'b1, "R2", 64'(resp_valid), 64'd1);
    chk(resp_hit == exp_hit, req, 64'(resp_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk(resp_data == ld(a), req, 64'(resp_data), 64'(ld(a)));
      chk(resp_dirty == exp_d, "R11", 64'(resp_dirty), 64'(exp_d));
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!resp_valid && !wb_valid, "R1", 64'({resp_valid, wb_valid}), 64'd0);
    lookup(20'h00010, 0, '0, 0, 0, 0, "R1");
  endtask

  task automatic t_fill_and_order();
    evict(20'h00100, 0, 0, '0, "R4");        // A
    evict(20'h00200, 1, 0, '0, "R4");        // B dirty
    evict(20'h00300, 0, 0, '0, "R4");        // C
    evict(20'h00400, 1, 0, '0, "R4");        // D dirty
    evict(20'h00500, 0, 0, '0, "R6");        // E replaces clean A
    evict(20'h00600, 1, 1, 20'h00200, "R5"); // F replaces dirty B
    lookup(20'h00300, 1, 20'h00700, 0, 1, 0, "R7"); // C out, G in
    lookup(20'h00400, 1, 20'h00800, 1, 1, 1, "R7"); // D out, H dirty in
    lookup(20'h0ABCD, 0, '0, 0, 0, 0, "R3");        // miss, no change
    lookup(20'h00300, 0, '0, 0, 0, 0, "R7");        // C left buffer
    evict(20'h00900, 1, 0, '0, "R9");         // I replaces clean E
    evict(20'h00A00, 0, 1, 20'h00600, "R3");  // J replaces F: order intact
    evict(20'h00B00, 0, 0, '0, "R9");         // K replaces clean G
    evict(20'h00C00, 0, 1, 20'h00800, "R9");  // L replaces swapped dirty H
  endtask

  task automatic t_free_entry();
    lookup(20'h00A00, 0, '0, 0, 1, 0, "R8");  // J freed
    lookup(20'h00A00, 0, '0, 0, 0, 0, "R8");
    evict(20'h00D00, 0, 0, '0, "R8");         // fills free slot, dirty I kept
    lookup(20'h00900, 0, '0, 0, 1, 1, "R8");  // I still present
  endtask

  task automatic t_collision();
    @(negedge clk);
    lk_valid = 1; lk_addr = 20'h00B00; dp_valid = 0;
    ev_valid = 1; ev_addr = 20'h00E00; ev_data = ld(20'h00E00); ev_dirty = 1;
    @(negedge clk);
    lk_valid = 0; ev_valid = 0;
    chk(resp_hit == 1'b1, "R10", 64'(resp_hit), 64'd1);
    chk(wb_valid == 1'b0, "R10", 64'(wb_valid), 64'd0);
    lookup(20'h00E00, 0, '0, 0, 0, 0, "R10");
  endtask

  initial begin
    t_reset();
    t_fill_and_order();
    t_free_entry();
    t_collision();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule